// File: doc/BRIEF.md
# Hard-Mute Power-Down and Recovery Sequencer

This block decides when a multi-channel PWM audio output stage may run. It drives the stage's gating signals: six channel-valid flags, gating for the positive and negative PWM halves, the master-clock-out enable, a clip-pin override, a full-attenuation override, a control-bus ignore flag and the bit-clock and frame-clock enables used in master mode. While the active-low power-down pin is held low, the stage sits in a hard-mute state. The block enters that state at once, without waiting for a clock edge. When the pin is released, the block leaves the state through a clocked sequence that ends in normal operation.

Two things set the recovery time. The first is how many master-clock cycles the active-low reset pin has been high before power-down was released: a long history selects the slow recovery, and anything shorter selects the fast one. The second is the master-clock activity flag: if the clock is not active at release, the block falls back to the fast recovery, and the timer does not start until the clock returns. Both recovery lengths are cycle-count parameters, so they can be shortened in simulation. The master clock `clk_i` clocks the block.

Top module: `mute_recovery_seq`

## Requirements
- R1: While `pdn_ni` is low, `valid_o` is 6'b000000, `pwm_p_en_o`, `pwm_m_en_o` and `mclk_out_en_o` are 0, and `clip_force_o` is 1. This takes effect as soon as `pdn_ni` falls, with no clock edge needed.
- R2: `atten_force_o` is 1 from the moment power-down is entered until the sequence reaches normal operation. There is no intermediate ramp value.
- R3: `bus_ignore_o` is 1 from power-down entry until the clocked release. It stays 1 after the first and second rising edges of `clk_i` that follow the rise of `pdn_ni`.
- R4: With `master_mode_i`=1, `bclk_en_o` and `lrclk_en_o` are 0 during power-down and 1 once it is left. With `master_mode_i`=0, both are always 0, so the pins stay inputs.
- R5: With the clock active, the release is seen on the third rising edge after `pdn_ni` rises. From that edge on, `bus_ignore_o` and `clip_force_o` are 0 and `mclk_out_en_o` is 1, while the audio path stays muted.
- R6: If `rst_ni` has been high for at least SLOW_THRESH (16) rising edges before `pdn_ni` rises, the recovery lasts SLOW_CYC cycles. With 15 or fewer edges it lasts FAST_CYC cycles. With a continuously active clock, normal operation starts on rising edge 4+delay after the release.
- R7: If `mclk_ok_i` is 0 at the release, the fast delay is used. The timer starts on the first rising edge that sees `mclk_ok_i`=1. If `mclk_ok_i` rises just after edge W (W≥3), normal operation starts on edge W+1+FAST_CYC.
- R8: All six `valid_o` bits rise together, and only on entry to normal operation. On that same edge `atten_force_o` falls and both PWM gates rise.
- R9: `rst_ni` low forces the power-down outputs immediately and clears the reset-age count. While `rst_ni` stays high the count saturates, so a later power-down pulse recovers slowly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset pin |
| pdn_ni | input | 1 | Active-low power-down pin |
| mclk_ok_i | input | 1 | Master clock activity indication |
| master_mode_i | input | 1 | 1: serial clocks generated locally; 0: serial clocks are inputs |
| valid_o | output | NUM_CH | Per-channel output-valid flags |
| pwm_p_en_o | output | 1 | Enable for positive PWM outputs (0 forces low) |
| pwm_m_en_o | output | 1 | Enable for negative PWM outputs (0 forces low) |
| mclk_out_en_o | output | 1 | Master-clock-out enable (0 forces low) |
| clip_force_o | output | 1 | Forces the clip pin high |
| atten_force_o | output | 1 | Forces volume to full attenuation with no ramp |
| bus_ignore_o | output | 1 | Control bus and serial data are to be ignored |
| bclk_en_o | output | 1 | Bit-clock generation enable in master mode |
| lrclk_en_o | output | 1 | Frame-clock generation enable in master mode |

## Verification
The main sequence is driven with several reset-high histories before release. These are well above the threshold, exactly at it, one cycle below it, and zero, where reset and power-down rise on the same edge. The at-threshold and one-below cases separate the slow and fast delays and expose any error in the synchroniser latency offset. Further vectors take the clock activity flag low at release for different gap lengths, which shows that the fast delay is chosen and that the timer start waits for the clock. Master and slave modes alternate across the vectors. Directed cases then drop power-down and reset between clock edges to prove asynchronous entry, and pulse power-down with reset held high to confirm that the saturated age count gives a slow recovery.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  typedef enum logic [1:0] {
    ST_PDOWN    = 2'd0,
    ST_WAIT_CLK = 2'd1,
    ST_RECOVER  = 2'd2,
    ST_RUN      = 2'd3
  } seq_state_e;
endpackage

// File: rtl/mrs_sync.sv
// Release detector: cleared asynchronously by either low input, shifts in ones afterwards.
module mrs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_ni,
  output logic rel_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni or negedge clr_ni) begin
    if (!rst_ni) begin
      ff_q <= '0;
    end else if (!clr_ni) begin
      ff_q <= '0;
    end else begin
      ff_q <= {ff_q[STAGES-2:0], 1'b1};
    end
  end

  assign rel_o = ff_q[STAGES-1];
endmodule

// File: rtl/mrs_age_cnt.sv
// Saturating count of clock edges seen while reset is high.
module mrs_age_cnt #(
  parameter int MAX = 18,
  localparam int W = $clog2(MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sat_o
);
  localparam logic [W-1:0] MAX_V = W'(MAX);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i && (cnt_q != MAX_V)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sat_o = (cnt_q == MAX_V);
endmodule

// File: rtl/mrs_timer.sv
// Loadable down-counter, holds at zero.
module mrs_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         en_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (en_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/mute_recovery_seq.sv
module mute_recovery_seq
  import mrs_pkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int SLOW_THRESH = 16,
  parameter int SLOW_CYC    = 2_400_000,
  parameter int FAST_CYC    = 110_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pdn_ni,
  input  logic              mclk_ok_i,
  input  logic              master_mode_i,
  output logic [NUM_CH-1:0] valid_o,
  output logic              pwm_p_en_o,
  output logic              pwm_m_en_o,
  output logic              mclk_out_en_o,
  output logic              clip_force_o,
  output logic              atten_force_o,
  output logic              bus_ignore_o,
  output logic              bclk_en_o,
  output logic              lrclk_en_o
);
  // Age count keeps running through the synchroniser delay; offset threshold to match.
  localparam int AGE_MAX  = SLOW_THRESH + SYNC_STAGES;
  localparam int DLY_MAX  = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
  localparam int TMR_W    = $clog2(DLY_MAX + 1);
  localparam logic [TMR_W-1:0] SLOW_LOAD = TMR_W'(SLOW_CYC - 1);
  localparam logic [TMR_W-1:0] FAST_LOAD = TMR_W'(FAST_CYC - 1);

  seq_state_e state_q, state_d;
  logic       slow_q, slow_d;
  logic       rel_seen;
  logic       age_sat;
  logic       tmr_load, tmr_en, tmr_zero;
  logic       in_pd, in_run;

  mrs_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_ni (pdn_ni),
    .rel_o  (rel_seen)
  );

  mrs_age_cnt #(
    .MAX (AGE_MAX)
  ) u_age (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mclk_ok_i),
    .sat_o  (age_sat)
  );

  mrs_timer #(
    .W (TMR_W)
  ) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (slow_q ? SLOW_LOAD : FAST_LOAD),
    .en_i       (tmr_en),
    .zero_o     (tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    slow_d   = slow_q;
    tmr_load = 1'b0;
    tmr_en   = 1'b0;
    unique case (state_q)
      ST_PDOWN: begin
        if (rel_seen) begin
          slow_d  = age_sat && mclk_ok_i;
          state_d = ST_WAIT_CLK;
        end
      end
      ST_WAIT_CLK: begin
        if (mclk_ok_i) begin
          tmr_load = 1'b1;
          state_d  = ST_RECOVER;
        end
      end
      ST_RECOVER: begin
        tmr_en = mclk_ok_i;
        if (mclk_ok_i && tmr_zero) begin
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        state_d = ST_RUN;
      end
      default: state_d = ST_PDOWN;
    endcase
  end

  // Entry is asynchronous on either pin; exit only through the clocked path.
  always_ff @(posedge clk_i or negedge rst_ni or negedge pdn_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PDOWN;
      slow_q  <= 1'b0;
    end else if (!pdn_ni) begin
      state_q <= ST_PDOWN;
      slow_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      slow_q  <= slow_d;
    end
  end

  assign in_pd  = (state_q == ST_PDOWN);
  assign in_run = (state_q == ST_RUN);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_valid
    assign valid_o[ch] = in_run;
  end

  assign pwm_p_en_o    = in_run;
  assign pwm_m_en_o    = in_run;
  assign atten_force_o = ~in_run;
  assign mclk_out_en_o = ~in_pd;
  assign clip_force_o  = in_pd;
  assign bus_ignore_o  = in_pd;
  assign bclk_en_o     = master_mode_i & ~in_pd;
  assign lrclk_en_o    = master_mode_i & ~in_pd;
endmodule

// File: rtl/mrs_checker.sv
module mrs_checker #(
  parameter int NUM_CH = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pdn_ni,
  input logic              mclk_ok_i,
  input logic              master_mode_i,
  input logic [NUM_CH-1:0] valid_o,
  input logic              pwm_p_en_o,
  input logic              pwm_m_en_o,
  input logic              mclk_out_en_o,
  input logic              clip_force_o,
  input logic              atten_force_o,
  input logic              bus_ignore_o,
  input logic              bclk_en_o,
  input logic              lrclk_en_o
);
  p_pd_outputs_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_ni |-> (valid_o == '0) && !pwm_p_en_o && !pwm_m_en_o && !mclk_out_en_o && clip_force_o);

  p_atten_pd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_ni |-> atten_force_o);

  p_bus_ignore_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_ni |-> bus_ignore_o);

  p_slave_clk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_mode_i |-> !bclk_en_o && !lrclk_en_o);

  p_release_sync_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_ignore_o) |-> pdn_ni && $past(pdn_ni) && $past(pdn_ni, 2));

  p_run_wait_clk_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o[0]) |-> $past(mclk_ok_i));

  p_valid_group_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o[0]) |-> (valid_o == '1) && !atten_force_o && $past(atten_force_o)
                          && pwm_p_en_o && pwm_m_en_o);

  p_no_valid_in_pd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ignore_o |-> (valid_o == '0));
endmodule

bind mute_recovery_seq mrs_checker #(
  .NUM_CH (NUM_CH)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pdn_ni        (pdn_ni),
  .mclk_ok_i     (mclk_ok_i),
  .master_mode_i (master_mode_i),
  .valid_o       (valid_o),
  .pwm_p_en_o    (pwm_p_en_o),
  .pwm_m_en_o    (pwm_m_en_o),
  .mclk_out_en_o (mclk_out_en_o),
  .clip_force_o  (clip_force_o),
  .atten_force_o (atten_force_o),
  .bus_ignore_o  (bus_ignore_o),
  .bclk_en_o     (bclk_en_o),
  .lrclk_en_o    (lrclk_en_o)
);

// File: tb/sim_mute_recovery_seq.sv
module sim_mute_recovery_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 6;
  localparam int SLOW_CYC   = 200;
  localparam int FAST_CYC   = 40;
  localparam int THRESH     = 16;

  typedef struct packed {
    int k;     // rising edges with reset high before release
    int w;     // 0: clock stays active; else clock flag returns after edge w
    bit m;     // master mode
    bit slow;  // expected delay choice
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{20, 0,  1'b1, 1'b1},
    '{16, 0,  1'b0, 1'b1},
    '{15, 0,  1'b1, 1'b0},
    '{0,  0,  1'b0, 1'b0},
    '{20, 10, 1'b1, 1'b0},
    '{3,  6,  1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni, pdn_ni, mclk_ok_i, master_mode_i;
  logic [NUM_CH-1:0] valid_o;
  logic pwm_p_en_o, pwm_m_en_o, mclk_out_en_o, clip_force_o;
  logic atten_force_o, bus_ignore_o, bclk_en_o, lrclk_en_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mute_recovery_seq #(
    .NUM_CH      (NUM_CH),
    .SLOW_THRESH (THRESH),
    .SLOW_CYC    (SLOW_CYC),
    .FAST_CYC    (FAST_CYC)
  ) u0 (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .pdn_ni        (pdn_ni),
    .mclk_ok_i     (mclk_ok_i),
    .master_mode_i (master_mode_i),
    .valid_o       (valid_o),
    .pwm_p_en_o    (pwm_p_en_o),
    .pwm_m_en_o    (pwm_m_en_o),
    .mclk_out_en_o (mclk_out_en_o),
    .clip_force_o  (clip_force_o),
    .atten_force_o (atten_force_o),
    .bus_ignore_o  (bus_ignore_o),
    .bclk_en_o     (bclk_en_o),
    .lrclk_en_o    (lrclk_en_o)
  );

  // {valid[5:0], pwm_p, pwm_m, mclk_out, clip, atten, bus_ignore, bclk, lrclk}
  function automatic logic [13:0] obs();
    return {valid_o, pwm_p_en_o, pwm_m_en_o, mclk_out_en_o, clip_force_o,
            atten_force_o, bus_ignore_o, bclk_en_o, lrclk_en_o};
  endfunction
  function automatic logic [13:0] exp_pd();
    return {6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  endfunction
  function automatic logic [13:0] exp_mid(input bit m);
    return {6'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, m, m};
  endfunction
  function automatic logic [13:0] exp_run(input bit m);
    return {6'h3f, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, m, m};
  endfunction

  task automatic chk(input string req, input logic [13:0] act, input logic [13:0] exp,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int dly, start, last;
    string rq;
    @(negedge clk);
    rst_ni = 1'b0; pdn_ni = 1'b0; mclk_ok_i = 1'b1; master_mode_i = v.m;
    repeat (3) @(negedge clk);
    chk("R1", obs(), exp_pd(), $sformatf("vec%0d held in power-down", idx));
    rst_ni = 1'b1;
    repeat (v.k) @(negedge clk);
    pdn_ni    = 1'b1;
    mclk_ok_i = (v.w == 0);
    dly   = v.slow ? SLOW_CYC : FAST_CYC;
    start = (v.w == 0) ? 4 : v.w + 1;
    last  = start + dly;
    rq    = (v.w != 0) ? "R7" : "R6";
    for (int e = 1; e <= last; e++) begin
      @(negedge clk);
      if (e == 2) chk("R3", obs(), exp_pd(), $sformatf("vec%0d still ignored after edge 2", idx));
      if (e == 3) chk("R5", obs(), exp_mid(v.m), $sformatf("vec%0d release on edge 3 (R4 clocks)", idx));
      if (e == last - 1) chk(rq, obs(), exp_mid(v.m), $sformatf("vec%0d muted one edge before end", idx));
      if (e == last) chk("R8", obs(), exp_run(v.m), $sformatf("vec%0d normal after %0d-cycle delay", idx, dly));
      if (v.w != 0 && e == v.w) mclk_ok_i = 1'b1;
    end
  endtask

  initial begin
    rst_ni = 1'b0; pdn_ni = 1'b0; mclk_ok_i = 1'b1; master_mode_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", obs(), exp_pd(), "reset state");

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R1 R2 R3: asynchronous entry between edges, from normal operation
    @(negedge clk);
    #2 pdn_ni = 1'b0;
    #1 chk("R1", obs(), exp_pd(), "async power-down entry without edge (R2 atten)");

    // R9: reset held high, short power-down pulse -> saturated count -> slow
    master_mode_i = 1'b1;
    repeat (3) @(negedge clk);
    pdn_ni = 1'b1;
    for (int e = 1; e <= 4 + SLOW_CYC; e++) begin
      @(negedge clk);
      if (e == 3 + SLOW_CYC) chk("R9", obs(), exp_mid(1'b1), "pulse with reset high still recovering");
      if (e == 4 + SLOW_CYC) chk("R9", obs(), exp_run(1'b1), "pulse with reset high slow recovery done");
    end

    // R9: reset drop forces power-down outputs without an edge
    #2 rst_ni = 1'b0;
    #1 chk("R9", obs(), exp_pd(), "async reset entry");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule